// File: doc/BRIEF.md
# Modem Handshake Control Register with Diagnostic Loopback

This block holds the control byte that a host processor writes to steer the modem handshake side of a serial port. Two of the stored bits drive active-low handshake output pins, one bit is plain storage with no pin, one bit gates the serial interrupt onto its pad, and one bit selects a diagnostic loopback. In normal operation the block passes the transmit serial stream to the TXD pin and the RXD pin to the receiver. It also inverts the four active-low handshake input pins into an active-high status view for a downstream status and interrupt block.

When loopback is selected, the block holds TXD at mark and feeds the transmit stream straight back into the receiver input. It drives both handshake output pins to their inactive high level. The status view then ignores the input pins and is sourced from four control bits instead, so software can raise modem-status events without any cable attached. The interrupt gate keeps working in both modes.

Top module: `modem_ctl_loop`

## Requirements
- R1: A write (`wr_en` high at a rising clock edge) stores `wr_data[4:0]`, and `rd_data[4:0]` shows the stored bits from that edge on.
- R2: Outside loopback, `dte_ready_n` is the inverse of control bit 0 and `send_req_n` is the inverse of control bit 1.
- R3: Control bit 2 is storage only: changing it moves neither handshake output pin nor TXD.
- R4: `irq_pad_oe` equals control bit 3 (1 = pad driven, 0 = pad released). `irq_pad` carries `irq_req` while the pad is driven and is 0 while it is released.
- R5: `rd_data[7:5]` always read 0, and writes to those bits have no effect.
- R6: With control bit 4 set, `txd_pin` is 1, `ser_rx_out` follows `ser_tx_in`, and `rxd_pin` has no effect. With bit 4 clear, `txd_pin` follows `ser_tx_in` and `ser_rx_out` follows `rxd_pin`.
- R7: Outside loopback, each status output is the inverse of its input pin: `st_clear`=~`clear_n`, `st_set_ready`=~`set_ready_n`, `st_ring`=~`ring_n`, `st_carrier`=~`carrier_n`.
- R8: In loopback the input pins have no effect, and the status outputs come from the control bits: `st_set_ready`=bit 0, `st_clear`=bit 1, `st_ring`=bit 2, `st_carrier`=bit 3.
- R9: In loopback, `dte_ready_n` and `send_req_n` are both 1, whatever bits 0 and 1 hold.
- R10: After reset the control byte reads 0x00, both handshake output pins are 1, `irq_pad_oe` is 0 and loopback is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Current control byte |
| ser_tx_in | input | 1 | Serial output of the transmit shifter |
| ser_rx_out | output | 1 | Serial input to the receive shifter |
| txd_pin | output | 1 | Transmit data pin |
| rxd_pin | input | 1 | Receive data pin |
| dte_ready_n | output | 1 | Terminal-ready handshake pin, active low |
| send_req_n | output | 1 | Send-request handshake pin, active low |
| clear_n | input | 1 | Clear-to-send handshake pin, active low |
| set_ready_n | input | 1 | Data-set-ready handshake pin, active low |
| ring_n | input | 1 | Ring handshake pin, active low |
| carrier_n | input | 1 | Carrier handshake pin, active low |
| st_clear | output | 1 | Clear-to-send status, active high |
| st_set_ready | output | 1 | Data-set-ready status, active high |
| st_ring | output | 1 | Ring status, active high |
| st_carrier | output | 1 | Carrier status, active high |
| irq_req | input | 1 | Serial interrupt request from the interrupt logic |
| irq_pad | output | 1 | Interrupt pad data |
| irq_pad_oe | output | 1 | Interrupt pad output enable |

## Verification
A register write that turns loopback on or off can land in the same cycle as an edge on the handshake input pins. The status view must then switch its source exactly at the write edge. The bench toggles the input pins and sets the write strobe at the same falling edge. Before the rising edge it checks that the status reflects the new pin levels. After the edge it checks that the status holds the control-bit values while the pins are changed again. The reverse switch, leaving loopback, is checked the same way.

// File: rtl/mdmc_pkg.sv
package mdmc_pkg;
  localparam int REG_W  = 8;
  localparam int IMPL_W = 5;
  localparam int LINES  = 4;

  // bit order is behaviour: software-visible positions
  typedef struct packed {
    logic loop;     // bit 4
    logic irq_en;   // bit 3
    logic aux_a;    // bit 2
    logic send_req; // bit 1
    logic term_rdy; // bit 0
  } ctl_t;

  // status line index: 0 clear, 1 set_ready, 2 ring, 3 carrier
  typedef logic [LINES-1:0] sts_vec_t;

  function automatic ctl_t ctl_from_byte(input logic [IMPL_W-1:0] b);
    return ctl_t'(b);
  endfunction

  function automatic logic [REG_W-1:0] ctl_to_byte(input ctl_t c);
    return {{(REG_W-IMPL_W){1'b0}}, c};
  endfunction

  // pin level for an active-low handshake output
  function automatic logic pin_level(input logic bit_v, input logic lb);
    return lb ? 1'b1 : ~bit_v;
  endfunction

  // control bits as seen on the status lines during loopback
  function automatic sts_vec_t lb_source(input ctl_t c);
    return {c.irq_en, c.aux_a, c.term_rdy, c.send_req};
  endfunction
endpackage

// File: rtl/mdmc_reg.sv
module mdmc_reg
  import mdmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output ctl_t             ctl,
  output logic [REG_W-1:0] rd_data
);
  logic unused_hi;
  assign unused_hi = ^wr_data[REG_W-1:IMPL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl <= '0;
    else if (wr_en) ctl <= ctl_from_byte(wr_data[IMPL_W-1:0]);
  end

  assign rd_data = ctl_to_byte(ctl);
endmodule

// File: rtl/mdmc_pins.sv
module mdmc_pins
  import mdmc_pkg::*;
(
  input  ctl_t ctl,
  input  logic ser_tx_in,
  input  logic rxd_pin,
  input  logic irq_req,
  output logic txd_pin,
  output logic ser_rx_out,
  output logic dte_ready_n,
  output logic send_req_n,
  output logic irq_pad,
  output logic irq_pad_oe
);
  logic lb_active;
  assign lb_active   = ctl.loop;
  assign txd_pin     = lb_active ? 1'b1 : ser_tx_in;
  assign ser_rx_out  = lb_active ? ser_tx_in : rxd_pin;
  assign dte_ready_n = pin_level(ctl.term_rdy, lb_active);
  assign send_req_n  = pin_level(ctl.send_req, lb_active);
  assign irq_pad_oe  = ctl.irq_en;
  assign irq_pad     = ctl.irq_en & irq_req;
endmodule

// File: rtl/mdmc_sts.sv
module mdmc_sts
  import mdmc_pkg::*;
(
  input  ctl_t     ctl,
  input  sts_vec_t ext_n,
  output sts_vec_t sts
);
  sts_vec_t lb_vec;
  assign lb_vec = lb_source(ctl);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign sts[i] = ctl.loop ? lb_vec[i] : ~ext_n[i];
  end
endmodule

// File: rtl/modem_ctl_loop.sv
module modem_ctl_loop
  import mdmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       ser_tx_in,
  output logic       ser_rx_out,
  output logic       txd_pin,
  input  logic       rxd_pin,
  output logic       dte_ready_n,
  output logic       send_req_n,
  input  logic       clear_n,
  input  logic       set_ready_n,
  input  logic       ring_n,
  input  logic       carrier_n,
  output logic       st_clear,
  output logic       st_set_ready,
  output logic       st_ring,
  output logic       st_carrier,
  input  logic       irq_req,
  output logic       irq_pad,
  output logic       irq_pad_oe
);
  ctl_t     ctl;
  sts_vec_t sts;
  sts_vec_t ext_n;

  assign ext_n = {carrier_n, ring_n, set_ready_n, clear_n};

  mdmc_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctl(ctl), .rd_data(rd_data)
  );

  mdmc_pins u_pins (
    .ctl(ctl), .ser_tx_in(ser_tx_in), .rxd_pin(rxd_pin), .irq_req(irq_req),
    .txd_pin(txd_pin), .ser_rx_out(ser_rx_out), .dte_ready_n(dte_ready_n),
    .send_req_n(send_req_n), .irq_pad(irq_pad), .irq_pad_oe(irq_pad_oe)
  );

  mdmc_sts u_sts (.ctl(ctl), .ext_n(ext_n), .sts(sts));

  assign st_clear     = sts[0];
  assign st_set_ready = sts[1];
  assign st_ring      = sts[2];
  assign st_carrier   = sts[3];
endmodule

// File: rtl/mdmc_checker.sv
module mdmc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       txd_pin,
  input logic       ser_tx_in,
  input logic       ser_rx_out,
  input logic       dte_ready_n,
  input logic       send_req_n,
  input logic       st_clear,
  input logic       st_set_ready,
  input logic       st_ring,
  input logic       st_carrier,
  input logic       irq_pad,
  input logic       irq_pad_oe
);
  p_wr_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[4:0] == $past(wr_data[4:0]));
  p_pins_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[4] |-> (dte_ready_n == !rd_data[0]) && (send_req_n == !rd_data[1]));
  p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[3] |-> !irq_pad_oe && !irq_pad);
  p_rsv_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:5] == 3'b000);
  p_lb_serial_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] |-> txd_pin && (ser_rx_out == ser_tx_in));
  p_lb_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] |-> {st_carrier, st_ring, st_clear, st_set_ready} == rd_data[3:0]);
  p_lb_pins_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] |-> dte_ready_n && send_req_n);
endmodule

bind modem_ctl_loop mdmc_checker u_mdmc_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .txd_pin(txd_pin), .ser_tx_in(ser_tx_in), .ser_rx_out(ser_rx_out),
  .dte_ready_n(dte_ready_n), .send_req_n(send_req_n),
  .st_clear(st_clear), .st_set_ready(st_set_ready), .st_ring(st_ring),
  .st_carrier(st_carrier), .irq_pad(irq_pad), .irq_pad_oe(irq_pad_oe)
);

// File: tb/test_modem_ctl_loop.sv
`timescale 1ns/1ps
module test_modem_ctl_loop;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic ser_tx_in = 1'b0, ser_rx_out, txd_pin, rxd_pin = 1'b1;
  logic dte_ready_n, send_req_n;
  logic clear_n = 1'b1, set_ready_n = 1'b1, ring_n = 1'b1, carrier_n = 1'b1;
  logic st_clear, st_set_ready, st_ring, st_carrier;
  logic irq_req = 1'b0, irq_pad, irq_pad_oe;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  modem_ctl_loop i_modem_ctl_loop (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  function automatic logic [3:0] sts_now();
    return {st_carrier, st_ring, st_set_ready, st_clear};
  endfunction

  task automatic t_reset();
    chk("R10 rd", rd_data, 8'h00);
    chk("R10 pins", {6'd0, dte_ready_n, send_req_n}, 8'h03);
    chk("R10 oe", {7'd0, irq_pad_oe}, 8'h00);
    ser_tx_in = 1'b0; #1;
    chk("R10 loop off txd", {7'd0, txd_pin}, 8'h00);
  endtask

  task automatic t_write_pins();
    wr(8'h01);
    chk("R1 rd 01", rd_data, 8'h01);
    chk("R2 bit0", {6'd0, dte_ready_n, send_req_n}, 8'h01);
    wr(8'h02);
    chk("R2 bit1", {6'd0, dte_ready_n, send_req_n}, 8'h02);
    wr(8'h03);
    chk("R1 rd 03", rd_data, 8'h03);
    chk("R2 both", {6'd0, dte_ready_n, send_req_n}, 8'h00);
  endtask

  task automatic t_aux_only();
    wr(8'h00); ser_tx_in = 1'b0; #1;
    wr(8'h04);
    chk("R3 rd", rd_data, 8'h04);
    chk("R3 pins", {5'd0, txd_pin, dte_ready_n, send_req_n}, 8'h03);
  endtask

  task automatic t_irq_gate();
    wr(8'h00); irq_req = 1'b1; #1;
    chk("R4 off", {6'd0, irq_pad_oe, irq_pad}, 8'h00);
    wr(8'h08);
    chk("R4 on req1", {6'd0, irq_pad_oe, irq_pad}, 8'h03);
    irq_req = 1'b0; #1;
    chk("R4 on req0", {6'd0, irq_pad_oe, irq_pad}, 8'h02);
  endtask

  task automatic t_reserved();
    wr(8'hE0);
    chk("R5 hi only", rd_data, 8'h00);
    wr(8'hFF);
    chk("R5 all ones", rd_data, 8'h1F);
  endtask

  task automatic t_serial_normal();
    wr(8'h00);
    for (int i = 0; i < 4; i++) begin
      ser_tx_in = i[0]; rxd_pin = i[1]; #1;
      chk("R6 normal", {6'd0, txd_pin, ser_rx_out}, {6'd0, i[0], i[1]});
    end
  endtask

  task automatic t_status_normal();
    wr(8'h0F);
    {carrier_n, ring_n, set_ready_n, clear_n} = 4'b1010; #1;
    chk("R7 a", {4'd0, sts_now()}, 8'h05);
    {carrier_n, ring_n, set_ready_n, clear_n} = 4'b0110; #1;
    chk("R7 b", {4'd0, sts_now()}, 8'h09);
  endtask

  task automatic t_loop();
    wr(8'h13);
    chk("R9 pins high", {6'd0, dte_ready_n, send_req_n}, 8'h03);
    for (int i = 0; i < 4; i++) begin
      ser_tx_in = i[0]; rxd_pin = i[1]; #1;
      chk("R6 loop", {6'd0, txd_pin, ser_rx_out}, {6'd0, 1'b1, i[0]});
    end
    // bit0->set_ready, bit1->clear, bit2->ring, bit3->carrier
    {carrier_n, ring_n, set_ready_n, clear_n} = 4'b0000; #1;
    chk("R8 13", {4'd0, sts_now()}, 8'h03);
    wr(8'h15);
    chk("R8 15", {4'd0, sts_now()}, 8'h06);
    {carrier_n, ring_n, set_ready_n, clear_n} = 4'b1111; #1;
    wr(8'h1A);
    chk("R8 1A", {4'd0, sts_now()}, 8'h09);
    chk("R9 1A", {6'd0, dte_ready_n, send_req_n}, 8'h03);
  endtask

  task automatic t_switch_same_cycle();
    wr(8'h00);
    @(negedge clk);
    {carrier_n, ring_n, set_ready_n, clear_n} = 4'b0011;
    wr_en = 1'b1; wr_data = 8'h1C; #1;
    chk("R7 pre-edge", {4'd0, sts_now()}, 8'h0C);
    @(negedge clk); wr_en = 1'b0;
    chk("R8 post-edge", {4'd0, sts_now()}, 8'h0C);
    {carrier_n, ring_n, set_ready_n, clear_n} = 4'b1100; #1;
    chk("R8 pins ignored", {4'd0, sts_now()}, 8'h0C);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h0C;
    @(negedge clk); wr_en = 1'b0;
    chk("R7 exit loop", {4'd0, sts_now()}, 8'h03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_pins();
    t_aux_only();
    t_irq_gate();
    t_reserved();
    t_serial_normal();
    t_status_normal();
    t_loop();
    t_switch_same_cycle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule